// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches up to eight general-purpose input pins and raises one combined interrupt line when a pin shows the event it has been set up for. Every pin has its own four configuration bits: a sense bit picks edge or level detection, a both-edges bit widens edge detection to either direction, a polarity bit picks the active level or edge direction, and an enable bit decides whether the pin's event reaches the interrupt output.

Pin inputs are brought into the clock domain through a two-stage synchronizer. An edge is a difference between the current and the previous synchronized sample. Edge events are held in a raw status bit until software clears them by writing a one. Level events track the synchronized pin directly. A masked status view and the OR-reduced interrupt line are formed from the raw status and the enables. A build-time parameter lists which pins reach a pad. Bits for absent pins cannot be written, read as zero and never report an event.

Software reaches the block through a flat register port: a 3-bit address, a write strobe, write data, and read data that is decoded without a clock.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. Address 0 is sense (0 edge, 1 level), 1 is both-edges, 2 is polarity, 3 is enable; these four read back what was written. Address 4 reads raw status, 5 reads masked status, 6 is the clear register and reads 0, and 7 reads 0.
- R2: With sense 0, both-edges 0 and polarity 1, a 0-to-1 change on a pin sets its raw status bit, and a 1-to-0 change does not.
- R3: With sense 0, both-edges 0 and polarity 0, a 1-to-0 change sets the raw bit, and a 0-to-1 change does not.
- R4: With sense 0 and both-edges 1, any change sets the raw bit, whatever the polarity bit holds.
- R5: With sense 1, the raw bit equals 1 while the synchronized pin equals the polarity bit, and the both-edges bit has no effect.
- R6: Writing a word to address 6 clears the latched edge status of each bit written as 1 and leaves the bits written as 0 untouched. An edge that arrives in the same cycle wins over the clear. Level status cannot be cleared while the level persists.
- R7: Masked status equals raw status AND enable. `irq` is 1 exactly when any masked status bit is 1.
- R8: For a pin that the PAD_PRESENT parameter marks absent (bit 5 by default), writes to its configuration bits have no effect, all its register bits read 0, and pin activity never sets its status.
- R9: Changing sense, both-edges or polarity while the pins are steady does not set any edge status.
- R10: A pin change driven before clock edge 1 shows in the raw edge status after clock edge 3, and not after clock edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | NPINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | NPINS | Register write data |
| rd_data | output | NPINS | Register read data for `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check several things. A detected edge in edge mode latches on the next clock. A clear with no competing edge empties the latch. A latch never rises without a preceding edge. Level-mode status tracks the synchronized pin. The synchronizer stages shift in order. Absent pins never hold configuration. `irq` is never high without an enabled raw bit. The bench scenarios show the rest. The polarity and both-edges selections give the right outcome for chosen pin transitions. The three-edge latency is exact. Clears act only on the bits written as 1. Reconfiguring over steady pins leaves status empty.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    REG_SENSE  = 3'd0,
    REG_BOTH   = 3'd1,
    REG_POL    = 3'd2,
    REG_ENABLE = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_CLEAR  = 3'd6
  } reg_addr_e;

  // Edge qualifier: a change that matches the chosen direction, or any change
  function automatic logic edge_match(input logic both, input logic pol,
                                      input logic cur, input logic prev);
    logic changed;
    changed = cur ^ prev;
    return changed & (both | (cur == pol));
  endfunction

  // Level qualifier: pin sits at the active polarity
  function automatic logic level_match(input logic pol, input logic cur);
    return cur == pol;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PAD_PRESENT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);

  logic [NPINS-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= pins_in & PAD_PRESENT;
      cur    <= stage1;
      prev   <= cur;
    end
  end

  // R10
  // sync_order_chk
  sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (prev == $past(cur)));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PAD_PRESENT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] sense,
  output logic [NPINS-1:0] both,
  output logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] clr
);

  logic [NPINS-1:0] wdata_q;
  assign wdata_q = wr_data & PAD_PRESENT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense  <= '0;
      both   <= '0;
      pol    <= '0;
      enable <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_SENSE:  sense  <= wdata_q;
        REG_BOTH:   both   <= wdata_q;
        REG_POL:    pol    <= wdata_q;
        REG_ENABLE: enable <= wdata_q;
        default: ;
      endcase
    end
  end

  assign clr = (wr_en && reg_addr_e'(addr) == REG_CLEAR) ? wdata_q : '0;

  // R8
  // absent_cfg_chk
  absent_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sense | both | pol | enable) & ~PAD_PRESENT) == '0);

endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic both,
  input  logic pol,
  input  logic cur,
  input  logic prev,
  input  logic clr,
  output logic edge_hit,
  output logic raw
);

  logic latch_q;
  logic lvl_hit;

  assign edge_hit = ~sense & edge_match(both, pol, cur, prev);
  assign lvl_hit  = level_match(pol, cur);

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= 1'b0;
    else if (sense)  latch_q <= 1'b0;
    else             latch_q <= (latch_q & ~clr) | edge_hit;
  end

  assign raw = sense ? lvl_hit : latch_q;

  // R2
  // edge_set_chk
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> latch_q);

  // R6
  // clear_take_chk
  clear_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !latch_q);

  // R9
  // no_spurious_chk
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(edge_hit));

  // R5
  // level_track_chk
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense |-> (raw == (cur == pol)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PAD_PRESENT = 8'hDF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] rd_data,
  output logic             irq
);

  logic [NPINS-1:0] cur, prev;
  logic [NPINS-1:0] sense, both, pol, enable, clr;
  logic [NPINS-1:0] edge_hit, raw, masked;

  gpio_pin_sync #(.NPINS(NPINS), .PAD_PRESENT(PAD_PRESENT)) sync_i (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .cur(cur), .prev(prev)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .PAD_PRESENT(PAD_PRESENT)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .sense(sense), .both(both), .pol(pol), .enable(enable), .clr(clr)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_event ev_i (
      .clk(clk), .rst_n(rst_n),
      .sense(sense[i]), .both(both[i]), .pol(pol[i]),
      .cur(cur[i]), .prev(prev[i]), .clr(clr[i]),
      .edge_hit(edge_hit[i]), .raw(raw[i])
    );
  end

  assign masked = raw & enable;
  assign irq    = |masked;

  always_comb begin
    case (reg_addr_e'(addr))
      REG_SENSE:  rd_data = sense;
      REG_BOTH:   rd_data = both;
      REG_POL:    rd_data = pol;
      REG_ENABLE: rd_data = enable;
      REG_RAW:    rd_data = raw;
      REG_MASKED: rd_data = masked;
      default:    rd_data = '0;
    endcase
  end

  // R7
  // irq_source_chk
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & enable) != '0));

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CONN = 8'hDF;

  typedef struct packed {
    logic [7:0] sense, both, pol, enable, p0, p1;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h0F},  // R2 rising
    '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hF0},  // R3 falling
    '{8'h00, 8'hFF, 8'h55, 8'hFF, 8'h0F, 8'h3C},  // R4 both edges
    '{8'hFF, 8'hAA, 8'hFF, 8'h0F, 8'h00, 8'hA5},  // R5 level high
    '{8'hFF, 8'h00, 8'h00, 8'hF0, 8'h00, 8'hA5},  // R5 level low
    '{8'h0F, 8'h33, 8'h5A, 8'hC3, 8'h96, 8'h69},  // R7 mixed
    '{8'h00, 8'h00, 8'h04, 8'h04, 8'h00, 8'hFF},  // R2 single pin
    '{8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF}   // R7 all disabled
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_in = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_raw(input vec_t v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (!CONN[i])                 r[i] = 1'b0;
      else if (v.sense[i])          r[i] = v.pol[i] ? v.p1[i] : ~v.p1[i];
      else if (v.p0[i] == v.p1[i])  r[i] = 1'b0;
      else if (v.both[i])           r[i] = 1'b1;
      else                          r[i] = v.pol[i] ? v.p1[i] : v.p0[i];
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] er;
    string tags [NVEC] = '{"R2", "R3", "R4", "R5", "R5", "R7", "R2", "R7"};
    settle(3);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    // Table of vectors
    for (int k = 0; k < NVEC; k++) begin
      wr(3'd0, VECS[k].sense);
      wr(3'd1, VECS[k].both);
      wr(3'd2, VECS[k].pol);
      wr(3'd3, VECS[k].enable);
      pins_in = VECS[k].p0;
      settle(5);
      wr(3'd6, 8'hFF);
      pins_in = VECS[k].p1;
      settle(5);
      er = model_raw(VECS[k]);
      rd(3'd4, d);
      check(tags[k], d, er);
      rd(3'd5, d);
      check("R7 masked", d, er & VECS[k].enable & CONN);
      check("R7 irq", {7'b0, irq}, {7'b0, |(er & VECS[k].enable & CONN)});
    end

    // R10 latency: rising on bit 0
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    pins_in = 8'h00;
    settle(5);
    wr(3'd6, 8'hFF);
    addr = 3'd4;
    pins_in = 8'h01;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    #1 check("R10 after edge 2", rd_data, 8'h00);
    @(posedge clk); @(negedge clk);
    #1 check("R10 after edge 3", rd_data, 8'h01);

    // R6 selective clear
    pins_in = 8'h03;
    settle(5);
    rd(3'd4, d);
    check("R6 two latched", d, 8'h03);
    wr(3'd6, 8'h01);
    rd(3'd4, d);
    check("R6 clear bit0 only", d, 8'h02);
    wr(3'd6, 8'h00);
    rd(3'd4, d);
    check("R6 zero write no effect", d, 8'h02);
    rd(3'd6, d);
    check("R1 clear reads 0", d, 8'h00);

    // R6 level status not clearable
    wr(3'd6, 8'hFF);
    wr(3'd0, 8'h80); wr(3'd2, 8'h80);
    pins_in = 8'h80;
    settle(5);
    wr(3'd6, 8'h80);
    rd(3'd4, d);
    check("R6 level persists", d & 8'h80, 8'h80);

    // R8 absent pin 5
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    check("R8 sense readback", d, 8'hDF);
    wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    pins_in = 8'h00;
    settle(5);
    wr(3'd6, 8'hFF);
    pins_in = 8'h20;
    settle(5);
    pins_in = 8'h00;
    settle(5);
    rd(3'd4, d);
    check("R8 absent raw", d, 8'h00);
    check("R8 absent irq", {7'b0, irq}, 8'h00);

    // R9 reconfigure over steady pins
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    pins_in = 8'h0F;
    settle(5);
    wr(3'd6, 8'hFF);
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    settle(4);
    rd(3'd4, d);
    check("R9 no spurious raw", d, 8'h00);

    rd(3'd7, d);
    check("R1 addr7 reads 0", d, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule